// File: doc/BRIEF.md
# Keypad Combination Lock

This block is a digital combination lock driven by a decimal keypad. A secret code of several decimal digits is taken from switch inputs, so the owner changes the combination by setting switches and never by touching the logic. The user presses keys one at a time. Each new press is turned into a single entry event, and the key value is compared with the stored digit for the current position.

Progress through the code is kept as a single 1 in a one-hot position register. Each correct digit moves that 1 one stage along. When the last digit is entered correctly the unlock output rises and stays high until the clear input is asserted. A wrong digit, or a press of several keys at once, sends the marker back to the first position and raises the error output for one clock cycle.

Top module: `code_lock`

## Requirements
- R1: After reset, unlock_o and error_o are low and the next entry is compared with the first code digit.
- R2: Code digit i sits in code_sw_i bits [4i+3:4i], and digit 0 is the first one entered. Key line k stands for decimal value k. A switch digit above 9 never matches.
- R3: Each press gives exactly one entry. A press is a rising edge of the OR of all key lines. Holding a key down gives no further entries.
- R4: A correct digit advances the position by one. unlock_o rises only after all NUM_DIGITS digits have been entered correctly in a row.
- R5: A wrong digit at any position returns the lock to the first position and holds error_o high for exactly one cycle.
- R6: If more than one key line is active when the entry is taken, the entry counts as a wrong digit.
- R7: unlock_o stays high until clear_i is asserted. clear_i drops unlock_o and error_o and returns the lock to the first position.
- R8: Presses made while unlock_o is high are ignored: unlock_o stays high and error_o stays low.
- R9: A new value on code_sw_i takes effect on the next comparison with no other action needed.
- R10: An entry updates the outputs on the third rising clock edge after the key line rises. The key lines pass through two synchronizer stages first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear: relocks and restarts entry |
| key_i | input | NUM_KEYS | One line per decimal key, active high, asynchronous |
| code_sw_i | input | NUM_DIGITS*4 | Switch-set code, four bits per digit |
| unlock_o | output | 1 | High once the full code has been entered |
| error_o | output | 1 | One-cycle pulse on a wrong entry |

## Verification
The assertions assume that each key press stays active longer than the two synchronizer stages, and that key lines are released between presses. Because of this, no two entry events fall on adjacent cycles. They also assume that clear_i is a synchronous level and that the switches do not change while an entry is being compared. The stimulus holds every press for four cycles and leaves a four-cycle gap after it. It changes the switches only while no key is down.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/code_lock_keyin.sv
module code_lock_keyin
    import code_lock_pkg::*;
#(
    parameter int NUM_KEYS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_i,
    output logic                strobe_o,
    output digit_t              digit_o,
    output logic                single_o
);
    typedef struct packed {
        logic [NUM_KEYS-1:0] meta;
        logic [NUM_KEYS-1:0] sync;
        logic                any_prev;
    } kin_t;

    kin_t s_q, s_d;
    logic any_now;

    always_comb begin
        s_d          = s_q;
        s_d.meta     = key_i;
        s_d.sync     = s_q.meta;
        s_d.any_prev = any_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        any_now  = |s_q.sync;
        strobe_o = any_now && !s_q.any_prev;
        single_o = ($countones(s_q.sync) == 1);
        digit_o  = '0;
        for (int k = 0; k < NUM_KEYS; k++)
            if (s_q.sync[k]) digit_o = digit_t'(k);
    end

    // R3: an entry event never lasts more than one cycle
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/code_lock_seq.sv
module code_lock_seq
    import code_lock_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          strobe_i,
    input  digit_t                        digit_i,
    input  logic                          single_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] code_i,
    output logic                          unlock_o,
    output logic                          error_o
);
    localparam logic [NUM_DIGITS-1:0] FIRST = NUM_DIGITS'(1);

    typedef struct packed {
        logic [NUM_DIGITS-1:0] pos;
        logic                  unlock;
        logic                  error;
    } seq_t;

    seq_t st_q, st_d;
    digit_t expect_dig;
    logic   hit;

    always_comb begin
        expect_dig = '0;
        for (int i = 0; i < NUM_DIGITS; i++)
            if (st_q.pos[i]) expect_dig |= code_i[i*DIGIT_W +: DIGIT_W];
        hit = single_i && (digit_i == expect_dig) && (digit_i <= digit_t'(9));
    end

    always_comb begin
        st_d       = st_q;
        st_d.error = 1'b0;
        if (clear_i) begin
            st_d.pos    = FIRST;
            st_d.unlock = 1'b0;
        end else if (strobe_i && !st_q.unlock) begin
            if (!hit) begin
                st_d.pos   = FIRST;
                st_d.error = 1'b1;
            end else if (st_q.pos[NUM_DIGITS-1]) begin
                st_d.pos    = FIRST;
                st_d.unlock = 1'b1;
            end else begin
                st_d.pos = st_q.pos << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pos: FIRST, unlock: 1'b0, error: 1'b0};
        else        st_q <= st_d;
    end

    assign unlock_o = st_q.unlock;
    assign error_o  = st_q.error;

    // R4: the progress marker always holds exactly one 1
    a_r4_marker_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.pos) == 1);
    // R4: unlock rises only from the last position on an entry
    a_r4_unlock_from_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.unlock) |-> $past(st_q.pos[NUM_DIGITS-1]) && $past(strobe_i));
    // R5: error is a single-cycle pulse and leaves the marker at the start
    a_r5_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.error |=> !st_q.error);
    a_r5_error_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.error |-> st_q.pos == FIRST);
    // R7: unlock holds until clear; clear relocks
    a_r7_unlock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unlock && !clear_i |=> st_q.unlock);
    a_r7_clear_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !st_q.unlock && !st_q.error && st_q.pos == FIRST);
    // R8: no error is flagged while open
    a_r8_quiet_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unlock |=> !st_q.error);
endmodule

// File: rtl/code_lock.sv
module code_lock
    import code_lock_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int NUM_KEYS   = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic [NUM_KEYS-1:0]           key_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] code_sw_i,
    output logic                          unlock_o,
    output logic                          error_o
);
    logic   strobe;
    logic   single;
    digit_t digit;

    code_lock_keyin #(.NUM_KEYS(NUM_KEYS)) u_keyin (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_i    (key_i),
        .strobe_o (strobe),
        .digit_o  (digit),
        .single_o (single)
    );

    code_lock_seq #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .strobe_i (strobe),
        .digit_i  (digit),
        .single_i (single),
        .code_i   (code_sw_i),
        .unlock_o (unlock_o),
        .error_o  (error_o)
    );
endmodule

// File: tb/test_code_lock.sv
module test_code_lock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic [9:0]  key_i = '0;
    logic [15:0] code_sw_i = 16'h7391;  // digits in entry order: 1,9,3,7
    logic        unlock_o, error_o;

    int errors = 0;
    int checks = 0;
    int err_cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    code_lock i_code_lock (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .key_i(key_i),
        .code_sw_i(code_sw_i), .unlock_o(unlock_o), .error_o(error_o)
    );

    always @(negedge clk) if (error_o) err_cycles++;

    // {key mask[9:0], expected unlock, expected error cycles}
    localparam logic [11:0] VEC [8] = '{
        {10'h002, 1'b0, 1'b0},   // R4 key 1 correct
        {10'h200, 1'b0, 1'b0},   // R4 key 9 correct
        {10'h020, 1'b0, 1'b1},   // R5 key 5 wrong
        {10'h002, 1'b0, 1'b0},   // R5 restart with 1
        {10'h200, 1'b0, 1'b0},
        {10'h008, 1'b0, 1'b0},
        {10'h080, 1'b1, 1'b0},   // R4 last digit opens
        {10'h004, 1'b1, 1'b0}    // R8 ignored while open
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic press(input logic [9:0] mask, input int hold);
        err_cycles = 0;
        @(negedge clk);
        key_i = mask;
        repeat (hold) @(negedge clk);
        key_i = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 unlock after reset", unlock_o, 0);
        check("R1 error after reset", error_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            press(VEC[v][11:2], 4);
            check($sformatf("R4/R5/R8 vec%0d unlock", v), unlock_o, VEC[v][1]);
            check($sformatf("R2/R5 vec%0d error cycles", v), err_cycles, VEC[v][0]);
        end

        // R7: clear relocks
        do_clear();
        check("R7 clear drops unlock", unlock_o, 0);

        // R10: latency of three rising edges
        err_cycles = 0;
        @(negedge clk); key_i = 10'h001;   // wrong for first digit 1
        @(negedge clk); check("R10 no error after 1 edge", error_o, 0);
        @(negedge clk); check("R10 no error after 2 edges", error_o, 0);
        @(negedge clk); check("R10 error after 3 edges", error_o, 1);
        @(negedge clk); check("R5 error gone next cycle", error_o, 0);
        key_i = '0; repeat (4) @(negedge clk);

        // R6: two keys together is a wrong digit (1 and 9)
        press(10'h202, 4);
        check("R6 multi-key error", err_cycles, 1);
        press(10'h002, 4); press(10'h200, 4); press(10'h008, 4); press(10'h080, 4);
        check("R6 marker restarted, code opens", unlock_o, 1);
        do_clear();

        // R5: wrong at last position restarts, not retries the position
        press(10'h002, 4); press(10'h200, 4); press(10'h008, 4);
        press(10'h008, 4);
        check("R5 wrong at last position error", err_cycles, 1);
        press(10'h080, 4);
        check("R5 last digit alone not enough", unlock_o, 0);
        check("R5 restart position expects 1", err_cycles, 1);

        // R3: a held key counts once
        press(10'h002, 20);
        check("R3 held key no extra entries", err_cycles, 0);
        press(10'h200, 4); press(10'h008, 4); press(10'h080, 4);
        check("R3 open after held first key", unlock_o, 1);
        do_clear();

        // R9: new switch code 0,0,0,0 takes effect immediately
        code_sw_i = 16'h0000;
        press(10'h001, 4); press(10'h001, 4); press(10'h001, 4);
        check("R9 three of four digits stays locked", unlock_o, 0);
        press(10'h001, 4);
        check("R9 new code opens", unlock_o, 1);
        check("R9 no error on new code", err_cycles, 0);
        do_clear();

        // R2: switch digit above 9 never matches (digit 0 = 0xA)
        code_sw_i = 16'h000A;
        press(10'h001, 4);
        check("R2 non-decimal digit mismatch", err_cycles, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule